// File: doc/BRIEF.md
# MII Station Management Front End

This block turns a register write into a PHY management transaction. Software writes a station word that carries a PHY address, a PHY register number and a direction bit. That write alone launches the operation. A companion 16-bit data register supplies the value for a write and receives the result of a read. The busy bit in the station word stays set until the operation completes.

Toward the PHYs the block presents a level request: a valid flag, the direction, a one-hot select, the 0-based index of the PHY, the register number and the write data. The request is held until the responder returns a single-cycle response with a success flag and read data. The responder can be a bank of register models or a serializer. An address outside the attached set completes without any request. A response that fails, or that does not arrive within the timeout window, is treated as an absent PHY. The block does no bit-level clocking of the management line.

Top module: `mii_sta_front`

## Requirements
- R1: A write to the station register (`csr_sel_i`=0) while idle starts a transaction. The station word layout is PHY address in bits 15:11, register number in bits 10:6, direction in bit 1 (1 = write, 0 = read) and busy in bit 0. Bits 15:1 read back as written, and bit 0 of the written value is not stored.
- R2: Busy (`sta_o[0]`) reads 1 from the clock edge that accepts the launch until the edge that completes it. For an attached PHY the completing edge is the one that sees `rsp_valid_i`. Busy is 0 otherwise.
- R3: For an attached PHY, `req_valid_o` is high for every cycle of the wait. During that time `req_write_o` equals the direction bit, `req_reg_o` equals the register number, and `req_wdata_o` equals the data register.
- R4: A read that receives `rsp_valid_i` with `rsp_ok_i`=1 loads `rsp_rdata_i` into the data register (`dat_o`).
- R5: A read that receives `rsp_valid_i` with `rsp_ok_i`=0 loads 0xFFFF into the data register.
- R6: A PHY address of 0, or an address above NUM_PHY, raises no request. The transaction completes one cycle after launch. A read loads 0xFFFF, and a write leaves the data register unchanged.
- R7: PHY addresses count from 1. Address N drives `req_idx_o` = N-1 and sets only bit N-1 of `req_sel_o`. `req_sel_o` is zero whenever no request is pending.
- R8: A station write while busy is ignored. The station fields and the pending request stay as they were.
- R9: If no response arrives within TIMEOUT (64) cycles of waiting, busy clears after exactly TIMEOUT busy cycles. A read loads 0xFFFF.
- R10: After reset the station word and the data register read 0, and no request is pending.
- R11: A write to the data register (`csr_sel_i`=1) while idle loads `csr_wdata_i` into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | 0 = station register, 1 = data register |
| csr_wdata_i | input | 16 | Register write value |
| sta_o | output | 16 | Station word readback, busy in bit 0 |
| dat_o | output | 16 | Data register readback |
| req_valid_o | output | 1 | Request pending toward a PHY |
| req_write_o | output | 1 | Request direction, 1 = write |
| req_idx_o | output | IDX_W (2) | 0-based index of the target PHY |
| req_sel_o | output | NUM_PHY (4) | One-hot PHY select, zero when idle |
| req_reg_o | output | 5 | PHY register number |
| req_wdata_o | output | 16 | Data sent on a write |
| rsp_valid_i | input | 1 | Single-cycle response strobe |
| rsp_ok_i | input | 1 | Response success flag |
| rsp_rdata_i | input | 16 | Read data in the response |

## Verification
The assertions take for granted that `rsp_valid_i` is only pulsed while `req_valid_o` is high, and that the data register is not written while busy, since either would change what a completion does. The stimulus raises a response only at a falling edge inside a pending request, holding it for one cycle. It changes the data register only between transactions. The only station writes made during a wait are the deliberate ones that test R8.

// File: rtl/mii_sta_pkg.sv
package mii_sta_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned FIELD_W  = 5;
  localparam int unsigned PHY_LO   = 11;
  localparam int unsigned REG_LO   = 6;
  localparam int unsigned OP_BIT   = 1;
  localparam int unsigned BUSY_BIT = 0;

  localparam logic SEL_STA = 1'b0;
  localparam logic SEL_DAT = 1'b1;

  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_FINISH = 2'd2
  } sta_state_e;
endpackage

// File: rtl/mii_sta_addr_map.sv
module mii_sta_addr_map
  import mii_sta_pkg::*;
#(
  parameter int unsigned NUM_PHY = 4,
  localparam int unsigned IDX_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic [FIELD_W-1:0] addr_i,
  output logic               present_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_PHY-1:0] sel_o
);
  // 1-based address: PHY g answers to address g+1
  for (genvar g = 0; g < NUM_PHY; g++) begin : g_sel
    assign sel_o[g] = (addr_i == FIELD_W'(g + 1));
  end

  assign present_o = |sel_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (sel_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mii_sta_timer.sv
module mii_sta_timer #(
  parameter int unsigned TIMEOUT = 64,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mii_sta_ctrl.sv
module mii_sta_ctrl
  import mii_sta_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic              csr_sel_i,
  input  logic [WORD_W-1:0] csr_wdata_i,
  input  logic              present_i,
  input  logic              expire_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_ok_i,
  input  logic [WORD_W-1:0] rsp_rdata_i,
  output logic [WORD_W-1:0] sta_o,
  output logic [WORD_W-1:0] dat_o,
  output logic              idle_o,
  output logic              waiting_o,
  output logic              launch_o
);
  sta_state_e        state_q, state_d;
  logic [WORD_W-1:0] sta_q, dat_q;
  logic              is_read, fill_ones, fill_rsp, host_dat;

  assign idle_o    = (state_q == ST_IDLE);
  assign waiting_o = (state_q == ST_WAIT);
  assign launch_o  = csr_we_i && (csr_sel_i == SEL_STA) && idle_o;
  assign host_dat  = csr_we_i && (csr_sel_i == SEL_DAT);
  assign is_read   = !sta_q[OP_BIT];

  always_comb begin
    state_d   = state_q;
    fill_ones = 1'b0;
    fill_rsp  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch_o) state_d = present_i ? ST_WAIT : ST_FINISH;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          state_d   = ST_IDLE;
          fill_rsp  = is_read && rsp_ok_i;
          fill_ones = is_read && !rsp_ok_i;
        end else if (expire_i) begin
          state_d   = ST_IDLE;
          fill_ones = is_read;
        end
      end
      ST_FINISH: begin
        state_d   = ST_IDLE;
        fill_ones = is_read;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sta_q   <= '0;
      dat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (launch_o) sta_q <= {csr_wdata_i[WORD_W-1:1], 1'b0};
      // completion wins over a host write in the same cycle
      if (fill_rsp)       dat_q <= rsp_rdata_i;
      else if (fill_ones) dat_q <= ALL_ONES;
      else if (host_dat)  dat_q <= csr_wdata_i;
    end
  end

  assign sta_o = sta_q | WORD_W'({!idle_o} << BUSY_BIT);
  assign dat_o = dat_q;
endmodule

// File: rtl/mii_sta_front.sv
module mii_sta_front
  import mii_sta_pkg::*;
#(
  parameter int unsigned NUM_PHY = 4,
  parameter int unsigned TIMEOUT = 64,
  localparam int unsigned IDX_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic               csr_sel_i,
  input  logic [15:0]        csr_wdata_i,
  output logic [15:0]        sta_o,
  output logic [15:0]        dat_o,
  output logic               req_valid_o,
  output logic               req_write_o,
  output logic [IDX_W-1:0]   req_idx_o,
  output logic [NUM_PHY-1:0] req_sel_o,
  output logic [4:0]         req_reg_o,
  output logic [15:0]        req_wdata_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_ok_i,
  input  logic [15:0]        rsp_rdata_i
);
  logic               idle, waiting, launch, present, expire;
  logic [FIELD_W-1:0] map_addr;
  logic [NUM_PHY-1:0] map_sel;
  logic [IDX_W-1:0]   map_idx;

  // one decoder: incoming address at launch, held address while pending
  assign map_addr = idle ? csr_wdata_i[PHY_LO +: FIELD_W] : sta_o[PHY_LO +: FIELD_W];

  mii_sta_addr_map #(.NUM_PHY(NUM_PHY)) u_map (
    .addr_i    (map_addr),
    .present_o (present),
    .idx_o     (map_idx),
    .sel_o     (map_sel)
  );

  mii_sta_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (launch),
    .run_i    (waiting),
    .expire_o (expire)
  );

  mii_sta_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_we_i    (csr_we_i),
    .csr_sel_i   (csr_sel_i),
    .csr_wdata_i (csr_wdata_i),
    .present_i   (present),
    .expire_i    (expire),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ok_i    (rsp_ok_i),
    .rsp_rdata_i (rsp_rdata_i),
    .sta_o       (sta_o),
    .dat_o       (dat_o),
    .idle_o      (idle),
    .waiting_o   (waiting),
    .launch_o    (launch)
  );

  assign req_valid_o = waiting;
  assign req_write_o = sta_o[OP_BIT];
  assign req_reg_o   = sta_o[REG_LO +: FIELD_W];
  assign req_idx_o   = map_idx;
  assign req_sel_o   = waiting ? map_sel : '0;
  assign req_wdata_o = dat_o;
endmodule

// File: rtl/mii_sta_front_chk.sv
module mii_sta_front_chk #(
  parameter int unsigned NUM_PHY = 4,
  parameter int unsigned TIMEOUT = 64,
  localparam int unsigned IDX_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               csr_we_i,
  input logic               csr_sel_i,
  input logic [15:0]        csr_wdata_i,
  input logic [15:0]        sta_o,
  input logic [15:0]        dat_o,
  input logic               req_valid_o,
  input logic               req_write_o,
  input logic [IDX_W-1:0]   req_idx_o,
  input logic [NUM_PHY-1:0] req_sel_o,
  input logic [4:0]         req_reg_o,
  input logic [15:0]        req_wdata_o,
  input logic               rsp_valid_i,
  input logic               rsp_ok_i,
  input logic [15:0]        rsp_rdata_i
);
  int unsigned busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_run <= 0;
    else if (sta_o[0]) busy_run <= busy_run + 1;
    else               busy_run <= 0;
  end

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !csr_sel_i && !sta_o[0]) |=> sta_o[0]); // R1

  AST_RSP_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && rsp_valid_i) |=> !sta_o[0]); // R2

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> sta_o[0]); // R3

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !rsp_valid_i) |=>
      (!req_valid_o || ($stable(req_reg_o) && $stable(req_write_o) && $stable(req_sel_o)))); // R3

  AST_READ_FAIL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && rsp_valid_i && !req_write_o && !rsp_ok_i) |=> (dat_o == 16'hFFFF)); // R5

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ($countones(req_sel_o) == 1)); // R7

  AST_SEL_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_o |-> (req_sel_o == '0)); // R7

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !csr_sel_i && sta_o[0]) |=> $stable(sta_o[15:1])); // R8

  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= TIMEOUT); // R9
endmodule

bind mii_sta_front mii_sta_front_chk #(.NUM_PHY(NUM_PHY), .TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/tb_mii_sta_front.sv
`timescale 1ns/1ps
module tb_mii_sta_front;
  localparam int NUM_PHY = 4;
  localparam int TIMEOUT = 64;
  localparam int IDX_W   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               csr_we = 1'b0, csr_sel = 1'b0;
  logic [15:0]        csr_wdata = '0;
  logic [15:0]        sta, dat, req_wdata, rsp_rdata = '0;
  logic               req_valid, req_write, rsp_valid = 1'b0, rsp_ok = 1'b0;
  logic [IDX_W-1:0]   req_idx;
  logic [NUM_PHY-1:0] req_sel;
  logic [4:0]         req_reg;

  int checks = 0, failures = 0;
  logic [15:0] mem [NUM_PHY][32];

  always #4 clk = ~clk;

  mii_sta_front #(.NUM_PHY(NUM_PHY), .TIMEOUT(TIMEOUT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_sel_i(csr_sel),
    .csr_wdata_i(csr_wdata), .sta_o(sta), .dat_o(dat), .req_valid_o(req_valid),
    .req_write_o(req_write), .req_idx_o(req_idx), .req_sel_o(req_sel),
    .req_reg_o(req_reg), .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid),
    .rsp_ok_i(rsp_ok), .rsp_rdata_i(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put_dat(input logic [15:0] v);
    @(negedge clk); csr_we = 1'b1; csr_sel = 1'b1; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  // returns at the falling edge after the accepting rising edge
  task automatic launch(input logic [4:0] phy, input logic [4:0] rg, input logic wr);
    @(negedge clk); csr_we = 1'b1; csr_sel = 1'b0;
    csr_wdata = {phy, rg, 4'b0000, wr, 1'b1};
    @(negedge clk); csr_we = 1'b0;
  endtask

  // waits 'delay' cycles, then one response; counts busy samples
  task automatic respond(input int delay, input logic ok, output int busy_n);
    busy_n = 0;
    repeat (delay) begin
      if (sta[0]) busy_n++;
      @(negedge clk);
    end
    if (sta[0]) busy_n++;
    rsp_valid = 1'b1; rsp_ok = ok;
    rsp_rdata = req_write ? 16'h0 : mem[req_idx][req_reg];
    if (req_write && ok) mem[req_idx][req_reg] = req_wdata;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_ok = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 station after reset", sta, 0);
    check("R10 data after reset", dat, 0);
    check("R10 no request after reset", {req_valid, req_sel}, 0);
  endtask

  task automatic t_write_txn;
    int b;
    put_dat(16'hA5A5);
    check("R11 data register load", dat, 16'hA5A5);
    launch(5'd1, 5'd3, 1'b1);
    check("R1 station fields", sta, {5'd1, 5'd3, 4'b0, 1'b1, 1'b1});
    check("R3 request valid", req_valid, 1);
    check("R3 request write", req_write, 1);
    check("R3 request reg", req_reg, 3);
    check("R3 request wdata", req_wdata, 16'hA5A5);
    check("R7 index of addr 1", req_idx, 0);
    check("R7 select of addr 1", req_sel, 4'b0001);
    respond(0, 1'b1, b);
    check("R2 busy cleared after write", sta[0], 0);
    check("R2 busy cycles write", b, 1);
    check("R3 model received data", mem[0][3], 16'hA5A5);
  endtask

  task automatic t_read_ok;
    int b;
    put_dat(16'h0000);
    launch(5'd1, 5'd3, 1'b0);
    check("R3 read direction", req_write, 0);
    respond(3, 1'b1, b);
    check("R2 busy held over delay", b, 4);
    check("R2 busy cleared after read", sta[0], 0);
    check("R4 read data", dat, 16'hA5A5);
    mem[3][31] = 16'h3C5A;
    launch(5'd4, 5'd31, 1'b0);
    check("R7 index of addr 4", req_idx, 3);
    check("R7 select of addr 4", req_sel, 4'b1000);
    respond(1, 1'b1, b);
    check("R4 read data addr 4", dat, 16'h3C5A);
    check("R7 no select when idle", req_sel, 0);
  endtask

  task automatic t_read_fail;
    int b;
    put_dat(16'h1111);
    launch(5'd2, 5'd7, 1'b0);
    respond(2, 1'b0, b);
    check("R5 failed read gives ones", dat, 16'hFFFF);
    check("R5 busy cleared", sta[0], 0);
  endtask

  task automatic t_absent;
    put_dat(16'h2222);
    launch(5'd0, 5'd1, 1'b0);
    check("R6 addr 0 busy", sta[0], 1);
    check("R6 addr 0 no request", req_valid, 0);
    @(negedge clk);
    check("R6 addr 0 done", sta[0], 0);
    check("R6 addr 0 read ones", dat, 16'hFFFF);
    put_dat(16'h3333);
    launch(5'd5, 5'd2, 1'b0);
    check("R6 addr 5 no request", {req_valid, req_sel}, 0);
    @(negedge clk);
    check("R6 addr 5 read ones", dat, 16'hFFFF);
    put_dat(16'h4444);
    launch(5'd31, 5'd2, 1'b1);
    check("R6 addr 31 no request", req_valid, 0);
    @(negedge clk);
    check("R6 absent write keeps data", dat, 16'h4444);
    check("R6 absent write done", sta[0], 0);
  endtask

  task automatic t_busy_ignore;
    int b;
    logic [15:0] held;
    mem[1][9] = 16'h5A5A;
    launch(5'd2, 5'd9, 1'b0);
    held = sta;
    @(negedge clk); csr_we = 1'b1; csr_sel = 1'b0;
    csr_wdata = {5'd3, 5'd4, 4'b0, 1'b1, 1'b0};
    @(negedge clk); csr_we = 1'b0;
    check("R8 station unchanged", sta, held);
    check("R8 request select unchanged", req_sel, 4'b0010);
    check("R8 request reg unchanged", req_reg, 9);
    respond(0, 1'b1, b);
    check("R8 original read completed", dat, 16'h5A5A);
    check("R8 no relaunch", sta[0], 0);
  endtask

  task automatic t_timeout;
    int b = 0;
    put_dat(16'h1234);
    launch(5'd3, 5'd0, 1'b0);
    while (sta[0] && b < 500) begin
      b++;
      @(negedge clk);
    end
    check("R9 busy cycles on timeout", b, TIMEOUT);
    check("R9 timeout read ones", dat, 16'hFFFF);
    check("R9 request dropped", req_valid, 0);
  endtask

  initial begin
    for (int p = 0; p < NUM_PHY; p++)
      for (int r = 0; r < 32; r++) mem[p][r] = 16'(p * 256 + r);
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_txn();
    t_read_ok();
    t_read_fail();
    t_absent();
    t_busy_ignore();
    t_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule